// File: doc/BRIEF.md
# Power-Save Clock Divider Controller

This block takes one fundamental clock and makes a slower CPU clock from it for a power-save mode. It does not generate a second clock. It produces a clock-enable strobe, `cpu_ce`, that the CPU and the on-chip peripherals use as a qualifier. Because the strobe is only stretched, the logic behind it keeps working at a reduced rate instead of stopping. One configuration word sets four things: the division ratio, the power-save enable, which clock each of the two clock outputs carries, and whether each output is driven.

A hardware interrupt drops the block out of power-save by itself, so interrupt handling runs at full speed. Software interrupts and traps leave the mode as it is. Each clock output, A and B, carries either the fundamental rate (a tick on every cycle) or the CPU rate. Each has its own drive enable. A ratio change, or a move into or out of power-save, starts only on a divided-period boundary, so the CPU never sees a shortened period.

Configuration word layout: bits [2:0] hold the divide code, bit 3 is power-save enable, bit 4 selects the clock for output A, bit 5 selects the clock for output B, bit 6 drives output A, and bit 7 drives output B. A select bit of 1 picks the CPU clock and 0 picks the fundamental clock.

Top module: `psclk_ctl`

## Requirements
- R1: After a synchronous active-low reset, power-save is off and the divide code is 0. Both outputs carry the fundamental clock and are driven, so `cpu_ce`, `outa_tick`, `outb_tick`, `outa_oe` and `outb_oe` are all 1 and `ps_mode` is 0.
- R2: While power-save is on, divide code k (0..7, from `cfg_wdata[2:0]`) makes `cpu_ce` pulse for one cycle once every 2^k fundamental cycles, which covers divide-by-1 to divide-by-128.
- R3: While power-save is off, `cpu_ce` is 1 on every fundamental cycle once the current period has ended.
- R4: A configuration write never shortens or stretches the divided period already in progress. The new ratio or mode applies from the period that starts after the next `cpu_ce` pulse.
- R5: `hw_irq` high at a clock edge clears power-save (`ps_mode` reads 0 after that edge), even when a write that sets power-save happens in the same cycle.
- R6: `sw_trap` has no effect on power-save or on any other setting. It changes no output.
- R7: An output whose select bit (bit 4 for A, bit 5 for B) is 1 ticks exactly when `cpu_ce` is 1. An output whose select bit is 0 ticks on every cycle.
- R8: An output whose drive bit (bit 6 for A, bit 7 for B) is 0 holds its tick low and its output enable low.
- R9: A write (`cfg_we` high at an edge) takes effect on `ps_mode`, the selects and the drive enables in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fundamental clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word (layout above) |
| hw_irq | input | 1 | Hardware interrupt, clears power-save |
| sw_trap | input | 1 | Software interrupt or trap, ignored |
| cpu_ce | output | 1 | CPU clock-enable strobe |
| ps_mode | output | 1 | Current power-save enable |
| outa_tick | output | 1 | Clock-enable for output A |
| outb_tick | output | 1 | Clock-enable for output B |
| outa_oe | output | 1 | Drive enable for output A |
| outb_oe | output | 1 | Drive enable for output B |

## Verification
Writes, `hw_irq` and `sw_trap` act on the register at the edge that samples them. `ps_mode`, the output selects and the enables therefore show their effect one cycle later. A ratio change appears in `cpu_ce` only after the pulse that ends the current period, which can be up to 128 cycles later. The bench drives stimulus on falling edges and advances its behavioural model on rising edges. It compares every output on the following falling edge, so each expected value is due exactly one edge after the stimulus. A separate gap measurement counts the falling edges between successive `cpu_ce` pulses, and it only starts after the first pulse that follows the write.

// File: rtl/psclk_pkg.sv
// Shared parameters and the configuration word type for the power-save
// clock controller. Assumes two clock outputs and a 3-bit divide code.
package psclk_pkg;
    localparam int DIV_W = 3;
    localparam int N_OUT = 2;
    localparam int CFG_W = DIV_W + 1 + 2 * N_OUT;

    typedef struct packed {
        logic [N_OUT-1:0] drv;    // per-output drive enable
        logic [N_OUT-1:0] sel;    // 1: CPU clock, 0: fundamental
        logic             ps_en;  // power-save enable
        logic [DIV_W-1:0] div;    // divide by 2**div
    } psclk_cfg_t;

    localparam psclk_cfg_t CFG_RESET = '{drv: '1, sel: '0, ps_en: 1'b0, div: '0};
endpackage

// File: rtl/psclk_cfg_reg.sv
// Configuration register. Loads on a write. A hardware interrupt clears
// the power-save bit and wins over a write in the same cycle. Software
// traps are accepted as an input but are deliberately ignored.
module psclk_cfg_reg
    import psclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  psclk_cfg_t wdata,
    input  logic       hw_irq,
    input  logic       sw_trap,
    output psclk_cfg_t cfg
);
    // Register update: reset, then write, then interrupt clear on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else begin
            if (we) begin
                cfg <= wdata;
            end
            if (hw_irq) begin
                cfg.ps_en <= 1'b0;
                if (we) begin
                    cfg.drv <= wdata.drv;
                    cfg.sel <= wdata.sel;
                    cfg.div <= wdata.div;
                end
            end
        end
    end

    p_hw_clears_ps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_irq |=> !cfg.ps_en)
        else $error("R5: power-save survived a hardware interrupt");

    p_sw_trap_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trap && !hw_irq && !we) |=> $stable(cfg))
        else $error("R6: software trap altered configuration");
endmodule

// File: rtl/psclk_divider.sv
// Power-save divider. Produces a one-cycle CPU clock-enable every
// 2**code cycles. The period length is reloaded only when a pulse is
// issued, so a new setting never truncates the running period.
module psclk_divider #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps_en,
    input  logic [DIV_W-1:0] div,
    output logic             cpu_ce
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] req_exp;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;

    // Requested period exponent: full rate unless power-save is on.
    always_comb begin
        req_exp = ps_en ? div : '0;
        span    = {{CNT_W{1'b0}}, 1'b1} << req_exp;
        reload  = CNT_W'(span - 1'b1);
    end

    assign cpu_ce = (cnt == '0);

    // Down-counter: reload at a boundary, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cpu_ce) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Cycles since the last pulse, kept for the period bound check.
    logic [CNT_W:0] gap;
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_ce) begin
            gap <= '0;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    p_period_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gap < (CNT_W + 1)'(1 << CNT_W))
        else $error("R2: divided period exceeded the largest divisor");

    p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_en && cpu_ce) |=> cpu_ce)
        else $error("R3: CPU enable dropped with power-save off");
endmodule

// File: rtl/psclk_out_route.sv
// Clock output routing. Each output ticks on every cycle (fundamental)
// or with the CPU enable, and is forced low when its drive bit is off.
module psclk_out_route #(
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_ce,
    input  logic [N_OUT-1:0] sel,
    input  logic [N_OUT-1:0] drv,
    output logic [N_OUT-1:0] tick,
    output logic [N_OUT-1:0] oe
);
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        // Per-output selection and gating.
        always_comb begin
            tick[g] = drv[g] & (sel[g] ? cpu_ce : 1'b1);
            oe[g]   = drv[g];
        end

        p_cpu_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[g] && !cpu_ce) |-> !tick[g])
            else $error("R7: CPU-selected output ticked without CPU enable");

        p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !oe[g] |-> !tick[g])
            else $error("R8: undriven output ticked");
    end
endmodule

// File: rtl/psclk_ctl.sv
// Top of the power-save clock controller: configuration register,
// divider and output routing. Assumes one fundamental clock domain.
module psclk_ctl
    import psclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             hw_irq,
    input  logic             sw_trap,
    output logic             cpu_ce,
    output logic             ps_mode,
    output logic             outa_tick,
    output logic             outb_tick,
    output logic             outa_oe,
    output logic             outb_oe
);
    psclk_cfg_t       cfg;
    logic [N_OUT-1:0] tick;
    logic [N_OUT-1:0] oe;

    psclk_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (psclk_cfg_t'(cfg_wdata)),
        .hw_irq  (hw_irq),
        .sw_trap (sw_trap),
        .cfg     (cfg)
    );

    psclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ps_en  (cfg.ps_en),
        .div    (cfg.div),
        .cpu_ce (cpu_ce)
    );

    psclk_out_route #(.N_OUT(N_OUT)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpu_ce (cpu_ce),
        .sel    (cfg.sel),
        .drv    (cfg.drv),
        .tick   (tick),
        .oe     (oe)
    );

    // Map the routed vectors onto the named output pins.
    always_comb begin
        ps_mode   = cfg.ps_en;
        outa_tick = tick[0];
        outb_tick = tick[1];
        outa_oe   = oe[0];
        outb_oe   = oe[1];
    end

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !hw_irq) |=> (ps_mode == $past(cfg_wdata[3])))
        else $error("R9: written power-save bit did not land");
endmodule

// File: tb/tb_psclk_ctl.sv
module tb_psclk_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       hw_irq = 1'b0;
    logic       sw_trap = 1'b0;
    logic       cpu_ce, ps_mode, outa_tick, outb_tick, outa_oe, outb_oe;

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    psclk_ctl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .hw_irq(hw_irq), .sw_trap(sw_trap), .cpu_ce(cpu_ce), .ps_mode(ps_mode),
        .outa_tick(outa_tick), .outb_tick(outb_tick),
        .outa_oe(outa_oe), .outb_oe(outb_oe)
    );

    // Behavioural reference model, advanced on rising edges.
    int m_div = 0, m_left = 0;
    bit m_ps = 0, m_sa = 0, m_sb = 0, m_da = 1, m_db = 1;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_ps = 0; m_sa = 0; m_sb = 0; m_da = 1; m_db = 1; m_left = 0;
        end else begin
            if (m_left == 0) m_left = (1 << (m_ps ? m_div : 0)) - 1;
            else m_left = m_left - 1;
            if (cfg_we) begin
                m_div = int'(cfg_wdata[2:0]); m_ps = cfg_wdata[3];
                m_sa = cfg_wdata[4]; m_sb = cfg_wdata[5];
                m_da = cfg_wdata[6]; m_db = cfg_wdata[7];
            end
            if (hw_irq) m_ps = 0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_ce;
            e_ce = (m_left == 0);
            chk(tag, "cpu_ce", cpu_ce, e_ce);
            chk(tag, "ps_mode", ps_mode, m_ps);
            chk(tag, "outa_tick", outa_tick, m_da & (m_sa ? e_ce : 1'b1));
            chk(tag, "outb_tick", outb_tick, m_db & (m_sb ? e_ce : 1'b1));
            chk(tag, "outa_oe", outa_oe, m_da);
            chk(tag, "outb_oe", outb_oe, m_db);
        end
    end

    function automatic logic [7:0] word(int dv, bit ps, bit sa, bit sb, bit da, bit db);
        return {db, da, sb, sa, ps, 3'(dv)};
    endfunction

    task automatic wr(input logic [7:0] w, input bit irq);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w; hw_irq = irq;
        @(negedge clk);
        cfg_we = 1'b0; hw_irq = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Cycles between the first two CPU pulses seen from now on.
    task automatic gap(output int n);
        while (!cpu_ce) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ce);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, checked directly at the ports
        chk("R1", "reset cpu_ce", cpu_ce, 1);
        chk("R1", "reset ps_mode", ps_mode, 0);
        chk("R1", "reset outa_tick", outa_tick, 1);
        chk("R1", "reset outb_oe", outb_oe, 1);
        tag = "R3";
        idle(5);
        gap(g);
        chk("R3", "full-rate gap", g, 1);

        // R2 every divide code, output A on CPU clock, B on fundamental
        tag = "R2";
        for (int k = 0; k < 8; k++) begin
            wr(word(k, 1, 1, 0, 1, 1), 0);
            gap(g);
            chk("R2", $sformatf("gap code %0d", k), g, 1 << k);
            idle(3);
        end

        // R4 change ratio mid-period: running period of 128 completes
        tag = "R4";
        wr(word(7, 1, 1, 1, 1, 1), 0);
        gap(g);
        idle(40);
        wr(word(1, 1, 1, 1, 1, 1), 0);
        g = 42;
        while (!cpu_ce) begin
            @(negedge clk);
            g++;
        end
        chk("R4", "period kept after write", g, 128);
        gap(g);
        chk("R4", "new period", g, 2);

        // R6 software trap keeps power-save
        tag = "R6";
        wr(word(3, 1, 1, 0, 1, 1), 0);
        @(negedge clk); sw_trap = 1'b1;
        @(negedge clk); sw_trap = 1'b0;
        chk("R6", "ps after trap", ps_mode, 1);
        gap(g);
        chk("R6", "ratio after trap", g, 8);

        // R5 hardware interrupt clears power-save
        tag = "R5";
        @(negedge clk); hw_irq = 1'b1;
        @(negedge clk); hw_irq = 1'b0;
        chk("R5", "ps after irq", ps_mode, 0);
        idle(10);
        gap(g);
        chk("R5", "full rate after irq", g, 1);
        wr(word(2, 1, 1, 1, 1, 1), 1);
        chk("R5", "irq beats write", ps_mode, 0);
        idle(10);

        // R9 / R7 / R8 select and drive combinations
        tag = "R9";
        wr(word(2, 1, 0, 1, 1, 1), 0);
        chk("R9", "ps after write", ps_mode, 1);
        tag = "R7";
        idle(20);
        tag = "R8";
        wr(word(2, 1, 1, 0, 0, 1), 0);
        idle(12);
        chk("R8", "A low when undriven", outa_tick, 0);
        wr(word(2, 1, 0, 1, 1, 0), 0);
        idle(12);
        chk("R8", "B oe off", outb_oe, 0);
        wr(word(0, 0, 0, 0, 0, 0), 0);
        idle(12);
        tag = "R3";
        wr(word(5, 0, 1, 1, 1, 1), 0);
        idle(10);
        gap(g);
        chk("R3", "code ignored with ps off", g, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule